// File: doc/BRIEF.md
# Multi-Converter Start Synchronizer with Phase Offset

This block decides the clock cycle in which each of several converter sequencers begins a sample. Software can start a module directly, or it can arm modules one by one and then issue a global release that starts every armed module in the same cycle. The write that carries the release may name a module of its own, and that module starts in the same cycle as the armed ones.

Each module also has its own trigger input. Several modules may be wired to one trigger or to separate triggers. A 4-bit phase value per module delays that module's trigger by a whole number of sixteenths of a common sample period. Phase 0 starts the module at once. Phase 8 starts it half a period later, so two modules that sample the same input at phases 0 and 8 give twice the sample rate. The delay is computed when the trigger arrives. A trigger that arrives while that module is still counting a delay is dropped, and the module's sticky overrun flag is set.

Top module: `msync`

## Requirements
- R1: After reset, every start strobe is low and every overrun flag is low.
- R2: A command whose arm and release flags are both low raises the strobe of each requested module in the cycle after the command, for one cycle only. No strobe appears unless a command or a trigger causes it.
- R3: A command with the arm flag set and the release flag clear produces no strobe. It marks the requested modules as armed.
- R4: A command with the release flag set strobes every armed module, together with every module named in that command, in the cycle after the command. It then clears all armed marks, so a second release with no requested modules strobes nothing.
- R5: When a command has both the arm and release flags set, the release takes precedence. The requested modules start at once and are not left armed.
- R6: A trigger on an idle module whose phase is 0 raises that module's strobe in the cycle after the trigger.
- R7: A trigger on an idle module with phase p raises its strobe D+1 cycles after the trigger, where D = floor(p × period / 16). When D is 0 this behaves like R6. The phase of module i is `phase[4i+3:4i]`.
- R8: Modules that share one trigger but have different phases start independently. With period 32, phase 0 starts in the cycle after the trigger and phase 8 starts 16 cycles later than that.
- R9: A trigger on a module that is still counting a delay is ignored: the pending strobe keeps its timing and no extra strobe is produced. The module's overrun flag rises, and other modules' flags do not change.
- R10: An overrun flag stays set until reset, even when the module later completes triggers normally.
- R11: The delay is fixed when the trigger arrives. Changing the period or phase while a delay is counting does not move the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | N | Per-module start request of a command |
| start_arm | input | 1 | Arm the requested modules instead of starting them |
| start_grel | input | 1 | Global release of all armed modules |
| trig | input | N | Per-module trigger pulse |
| period | input | PW | Common sample period in clocks |
| phase | input | 4*N | Phase value per module, 4 bits each |
| start_o | output | N | Per-module start strobe |
| ovr_o | output | N | Sticky per-module trigger overrun flag |

## Verification
The bench releases a group of armed modules together with a freshly requested module, and checks that none of them starts early and that the release clears every armed mark. A design that missed the requested module, or that left modules armed, would strobe too few modules or strobe again on the second release. The bench uses phase and period pairs whose products are not multiples of 16, including one whose delay rounds down to zero. A design that rounded up, or that counted one cycle too many or too few, would move the strobe by a cycle. The bench also re-triggers a module during its delay and changes the period while a count is running. A design that reloaded the counter or read the period late would produce a second strobe or a shifted one. A design that cleared the overrun flag would lose it after the next clean trigger.

// File: rtl/msync.sv
module msync #(
  parameter int N  = 4,
  parameter int PW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    start_req,
  input  logic            start_arm,
  input  logic            start_grel,
  input  logic [N-1:0]    trig,
  input  logic [PW-1:0]   period,
  input  logic [4*N-1:0]  phase,
  output logic [N-1:0]    start_o,
  output logic [N-1:0]    ovr_o
);
  localparam int MW = PW + 4;

  logic [N-1:0]  armed, busy, tfire;
  logic [PW-1:0] cnt [N];
  logic [PW-1:0] dly [N];
  logic [N-1:0]  cmd_fire;

  assign cmd_fire = start_grel ? (armed | start_req) : (start_arm ? '0 : start_req);

  for (genvar i = 0; i < N; i++) begin : g_mod
    logic [MW-1:0] prod;
    assign prod   = {{PW{1'b0}}, phase[4*i +: 4]} * {4'b0, period};
    assign dly[i] = prod[MW-1:4];
    assign tfire[i] = busy[i] ? (cnt[i] == PW'(1)) : (trig[i] && dly[i] == '0);

    assert_zero_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (trig[i] && !busy[i] && phase[4*i +: 4] == 4'd0) |=> start_o[i]);
    assert_count_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy[i] |-> cnt[i] != '0);
    assert_retrig_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[i] && trig[i]) |=> ovr_o[i]);
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_o[i] |=> ovr_o[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= '0;
      busy    <= '0;
      start_o <= '0;
      ovr_o   <= '0;
      for (int i = 0; i < N; i++) cnt[i] <= '0;
    end else begin
      armed   <= start_grel ? '0 : (armed | (start_arm ? start_req : '0));
      start_o <= cmd_fire | tfire;
      for (int i = 0; i < N; i++) begin
        if (busy[i]) begin
          cnt[i] <= cnt[i] - PW'(1);
          if (cnt[i] == PW'(1)) busy[i] <= 1'b0;
          if (trig[i]) ovr_o[i] <= 1'b1;
        end else if (trig[i] && dly[i] != '0) begin
          busy[i] <= 1'b1;
          cnt[i]  <= dly[i];
        end
      end
    end
  end

  assert_release_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_grel |=> ((start_o & $past(armed)) == $past(armed)));
  assert_release_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_grel |=> armed == '0);
endmodule

// File: tb/sim_msync.sv
module sim_msync;
  localparam int N = 4, PW = 8;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] start_req = '0, trig = '0;
  logic start_arm = 0, start_grel = 0;
  logic [PW-1:0] period = '0;
  logic [4*N-1:0] phase = '0;
  logic [N-1:0] start_o, ovr_o;

  always #4 clk = ~clk;

  msync #(.N(N), .PW(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .start_arm(start_arm),
    .start_grel(start_grel), .trig(trig), .period(period), .phase(phase),
    .start_o(start_o), .ovr_o(ovr_o)
  );

  typedef struct { int cyc; logic [N-1:0] mask; string tag; } item_t;
  item_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit mon_on = 0, done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int c, logic [N-1:0] m, string t);
    item_t it;
    it.cyc = c; it.mask = m; it.tag = t;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    logic [N-1:0] m;
    string t;
    bit any;
    if (mon_on) begin
      m = '0; t = "R2"; any = 0;
      for (int k = q.size() - 1; k >= 0; k--)
        if (q[k].cyc == cyc) begin
          m |= q[k].mask; t = q[k].tag; any = 1; q.delete(k);
        end
      if (any || start_o != '0) begin
        checks++;
        if (start_o !== m) begin
          errors++;
          $display("FAIL %s cycle %0d start_o=%b expected %b", t, cyc, start_o, m);
        end
      end
    end
  end

  task automatic chk(logic [N-1:0] act, logic [N-1:0] exp, string t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", t, act, exp);
    end
  endtask

  task automatic cmd(logic [N-1:0] r, logic a, logic g, output int b);
    @(negedge clk);
    start_req = r; start_arm = a; start_grel = g; b = cyc;
  endtask

  task automatic fire(logic [N-1:0] t, output int b);
    @(negedge clk);
    trig = t; b = cyc;
  endtask

  task automatic idle;
    @(negedge clk);
    start_req = '0; start_arm = 0; start_grel = 0; trig = '0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int b, b2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(start_o, '0, "R1 strobes");
    chk(ovr_o, '0, "R1 overrun");
    mon_on = 1;

    cmd(4'b0001, 0, 0, b); expect_at(b + 1, 4'b0001, "R2"); expect_at(b + 2, '0, "R2"); idle();
    repeat (3) @(negedge clk);

    cmd(4'b0010, 1, 0, b); expect_at(b + 1, '0, "R3"); idle();
    cmd(4'b0100, 1, 0, b); expect_at(b + 1, '0, "R3"); idle();
    repeat (3) @(negedge clk);

    cmd(4'b1000, 0, 1, b); expect_at(b + 1, 4'b1110, "R4"); idle();
    cmd(4'b0000, 0, 1, b); expect_at(b + 1, '0, "R4"); idle();

    cmd(4'b0001, 1, 1, b); expect_at(b + 1, 4'b0001, "R5"); idle();
    cmd(4'b0000, 0, 1, b); expect_at(b + 1, '0, "R5"); idle();
    repeat (3) @(negedge clk);

    period = 8'd32;
    phase = {4'd15, 4'd3, 4'd8, 4'd0};
    fire(4'b1111, b);
    expect_at(b + 1, 4'b0001, "R6");
    expect_at(b + 17, 4'b0010, "R8");
    expect_at(b + 7, 4'b0100, "R7");
    expect_at(b + 31, 4'b1000, "R7");
    idle();
    repeat (40) @(negedge clk);

    fire(4'b0010, b); expect_at(b + 17, 4'b0010, "R9"); idle();
    repeat (3) @(negedge clk);
    fire(4'b0011, b2); expect_at(b2 + 1, 4'b0001, "R9"); idle();
    repeat (20) @(negedge clk);
    chk(ovr_o, 4'b0010, "R9 overrun flag");
    fire(4'b0010, b); expect_at(b + 17, 4'b0010, "R10"); idle();
    repeat (20) @(negedge clk);
    chk(ovr_o, 4'b0010, "R10 flag kept");

    fire(4'b0100, b); expect_at(b + 7, 4'b0100, "R11");
    idle();
    period = 8'd100;
    phase[11:8] = 4'd15;
    repeat (12) @(negedge clk);

    period = 8'd20;
    phase = {4'd15, 4'd3, 4'd1, 4'd0};
    fire(4'b1110, b);
    expect_at(b + 19, 4'b1000, "R7");
    expect_at(b + 4, 4'b0100, "R7");
    expect_at(b + 2, 4'b0010, "R7");
    idle();
    repeat (25) @(negedge clk);

    period = 8'd10;
    fire(4'b0010, b); expect_at(b + 1, 4'b0010, "R7"); idle();
    repeat (5) @(negedge clk);

    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2 %0d expected strobes never checked, expected 0", q.size());
    end
    chk(ovr_o, 4'b0010, "R10 final");
    done = 1;
    summary();
    $finish;
  end
endmodule